// File: doc/BRIEF.md
# String Instruction Address Stepper

This block carries out a single pass of a string operation (move, compare, scan, load or store) at byte or word size. When `start` is accepted, it latches the operand pointers, the segment values, the accumulator and the direction flag. It then works through the byte-wide memory accesses the operation needs, one request at a time, on a request/acknowledge port. When the last access is acknowledged it produces the stepped pointers, along with the loaded accumulator or the two compare operands.

A word access is split into two byte accesses: the low byte at the offset and the high byte at the offset plus one. The sequencer around the block decides whether to issue another pass. Flag computation from the compare operands happens outside this block.

Top module: `str_step`

## Requirements
- R1: When `dir_down` is 0, each stepped pointer grows by 1 for a byte operation and by 2 for a word operation. When `dir_down` is 1 it shrinks by the same amount. Arithmetic wraps modulo 2^16. A pointer the operation does not step is returned unchanged on `si_out`/`di_out`.
- R2: Source accesses use address `ds_in*16 + si_in`. Destination accesses use `es_in*16 + di_in`. The address is truncated to 20 bits. The second byte of a word sits at offset+1, and that offset wraps modulo 2^16 before the segment is added.
- R3: Move (`op`=0) reads the source bytes low then high, writes the same bytes to the destination low then high, and steps both pointers.
- R4: Compare (`op`=1) reads the source bytes, then the destination bytes, and writes nothing. It presents `cmp_a`=source value and `cmp_b`=destination value (zero-extended for byte size) and steps both pointers.
- R5: Scan (`op`=2) reads only destination bytes. It presents `cmp_a`=accumulator (the low byte zero-extended for byte size) and `cmp_b`=destination value, and steps only the destination pointer.
- R6: Load (`op`=3) reads only source bytes and steps only the source pointer. A word load replaces all of `acc_out`. A byte load replaces the low byte and keeps the high byte of `acc_in`.
- R7: Store (`op`=4) writes the accumulator to the destination, low byte then high byte, and steps only the destination pointer.
- R8: `mem_req` stays high with the same `mem_addr`, `mem_we` and `mem_wdata` until `mem_ack` is sampled high. Each acknowledge completes exactly one byte access.
- R9: `done` is a one-cycle pulse in the cycle after the clock edge that samples the final acknowledge, and `si_out`/`di_out` hold the new values from that cycle on. `cmp_valid` (compare or scan) and `acc_load` (load) pulse together with `done`.
- R10: A `start` with `op` of 5, 6 or 7 is ignored, and so is a `start` while an access is pending. Neither issues a request nor disturbs the pass in progress.
- R11: After reset, no request is pending, all pulses are low, and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one pass |
| op | input | 3 | Operation: 0 move, 1 compare, 2 scan, 3 load, 4 store |
| is_word | input | 1 | 1 = word size, 0 = byte size |
| dir_down | input | 1 | 1 = pointers decrement |
| si_in | input | 16 | Source offset |
| di_in | input | 16 | Destination offset |
| ds_in | input | 16 | Source segment |
| es_in | input | 16 | Destination segment |
| acc_in | input | 16 | Accumulator value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access completes at this edge |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| done | output | 1 | Pass finished |
| si_out | output | 16 | Updated source offset |
| di_out | output | 16 | Updated destination offset |
| acc_out | output | 16 | Loaded accumulator |
| acc_load | output | 1 | `acc_out` updated this pass |
| cmp_a | output | 16 | First compare operand (minuend) |
| cmp_b | output | 16 | Second compare operand (subtrahend) |
| cmp_valid | output | 1 | Compare operands updated this pass |

## Verification
A wrong phase or byte-lane state shows on the memory port in the very next request cycle: as an address from the wrong segment or offset, a read where a write belongs, or an extra or missing access. Such errors are therefore caught at the first request that differs from the per-clock reference. A corrupted capture buffer or pointer register stays hidden until the cycle of `done`. At that point it appears as a wrong `si_out`, `di_out`, `acc_out` or compare operand, and it stays visible on those held outputs until the next pass.

// File: rtl/str_step_pkg.sv
// Shared types and per-operation role decoding for the string stepper.
// Assumes operation codes 0..4; the other codes are treated as illegal.
package str_step_pkg;

    typedef enum logic [2:0] {
        SOP_MOVE    = 3'd0,
        SOP_COMPARE = 3'd1,
        SOP_SCAN    = 3'd2,
        SOP_LOAD    = 3'd3,
        SOP_STORE   = 3'd4
    } sop_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SRC_RD = 2'd1,
        PH_DST_RD = 2'd2,
        PH_DST_WR = 2'd3
    } phase_e;

    // True for an operation code the block executes.
    function automatic logic op_legal(input logic [2:0] op);
        return op <= 3'd4;
    endfunction

    // True when the operation reads from the source pointer.
    function automatic logic reads_src(input logic [2:0] op);
        return (op == SOP_MOVE) || (op == SOP_COMPARE) || (op == SOP_LOAD);
    endfunction

    // True when the operation reads from the destination pointer.
    function automatic logic reads_dst(input logic [2:0] op);
        return (op == SOP_COMPARE) || (op == SOP_SCAN);
    endfunction

    // True when the operation writes to the destination pointer.
    function automatic logic writes_dst(input logic [2:0] op);
        return (op == SOP_MOVE) || (op == SOP_STORE);
    endfunction

    // True when the operation advances the source pointer.
    function automatic logic steps_si(input logic [2:0] op);
        return (op == SOP_MOVE) || (op == SOP_COMPARE) || (op == SOP_LOAD);
    endfunction

    // True when the operation advances the destination pointer.
    function automatic logic steps_di(input logic [2:0] op);
        return (op == SOP_MOVE) || (op == SOP_COMPARE) ||
               (op == SOP_SCAN) || (op == SOP_STORE);
    endfunction

    // Phase order is always source read, destination read, destination write.
    function automatic phase_e phase_after(input logic [2:0] op, input phase_e p);
        phase_e n;
        n = PH_IDLE;
        case (p)
            PH_IDLE: begin
                if (reads_src(op))       n = PH_SRC_RD;
                else if (reads_dst(op))  n = PH_DST_RD;
                else if (writes_dst(op)) n = PH_DST_WR;
            end
            PH_SRC_RD: begin
                if (reads_dst(op))       n = PH_DST_RD;
                else if (writes_dst(op)) n = PH_DST_WR;
            end
            PH_DST_RD: begin
                if (writes_dst(op))      n = PH_DST_WR;
            end
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/str_step_seq.sv
// Access sequencer: walks the phases of one pass and the byte lanes inside
// each phase, advancing one lane per memory acknowledge.
// Assumes mem_ack is only high while a request is outstanding.
module str_step_seq
    import str_step_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              is_word,
    input  logic              mem_ack,
    output phase_e            phase,
    output logic [LANE_W-1:0] lane,
    output logic [2:0]        op_q,
    output logic              word_q,
    output logic              accept,
    output logic              final_ack
);

    localparam int LAST_WORD_LANE = LANES - 1;

    logic   lane_end;
    phase_e nxt_ph;

    // Accept a new pass only when idle and the code is legal.
    always_comb accept = start && (phase == PH_IDLE) && op_legal(op);

    // Detect the last lane of the current phase and the phase that follows.
    always_comb begin
        lane_end = word_q ? (lane == LANE_W'(LAST_WORD_LANE)) : (lane == '0);
        nxt_ph   = phase_after(op_q, phase);
    end

    // The final acknowledge closes the last lane of the last phase.
    always_comb final_ack = mem_ack && (phase != PH_IDLE) && lane_end && (nxt_ph == PH_IDLE);

    // Phase and lane state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            lane   <= '0;
            op_q   <= '0;
            word_q <= 1'b0;
        end else if (accept) begin
            op_q   <= op;
            word_q <= is_word;
            phase  <= phase_after(op, PH_IDLE);
            lane   <= '0;
        end else if ((phase != PH_IDLE) && mem_ack) begin
            if (lane_end) begin
                lane  <= '0;
                phase <= nxt_ph;
            end else begin
                lane <= lane + 1'b1;
            end
        end
    end

endmodule

// File: rtl/str_step_agu.sv
// Address unit: forms segment*16+offset addresses for the active phase and
// steps the pointers at the end of a pass.
// Assumes ADDR_W >= OFS_W and that LANES fits in OFS_W bits.
module str_step_agu
    import str_step_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20,
    parameter int LANES     = 2,
    parameter int LANE_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              dir_down,
    input  logic [OFS_W-1:0]  si_in,
    input  logic [OFS_W-1:0]  di_in,
    input  logic [OFS_W-1:0]  ds_in,
    input  logic [OFS_W-1:0]  es_in,
    input  phase_e            phase,
    input  logic [LANE_W-1:0] lane,
    input  logic [2:0]        op_q,
    input  logic              word_q,
    input  logic              final_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [OFS_W-1:0]  si_out,
    output logic [OFS_W-1:0]  di_out
);

    logic [OFS_W-1:0]  si_q, di_q, ds_q, es_q;
    logic              dir_q;
    logic [OFS_W-1:0]  ofs, nb, step;
    logic [ADDR_W-1:0] seg_ext;

    // Latch the pass operands at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_q  <= '0;
            di_q  <= '0;
            ds_q  <= '0;
            es_q  <= '0;
            dir_q <= 1'b0;
        end else if (accept) begin
            si_q  <= si_in;
            di_q  <= di_in;
            ds_q  <= ds_in;
            es_q  <= es_in;
            dir_q <= dir_down;
        end
    end

    // Form the byte address; the offset wraps before the segment is added.
    always_comb begin
        ofs      = ((phase == PH_SRC_RD) ? si_q : di_q) + OFS_W'(lane);
        seg_ext  = ADDR_W'((phase == PH_SRC_RD) ? ds_q : es_q) << SEG_SHIFT;
        mem_addr = seg_ext + ADDR_W'(ofs);
    end

    // Signed step size from the operand size and direction.
    always_comb begin
        nb   = word_q ? OFS_W'(LANES) : OFS_W'(1);
        step = dir_q ? (OFS_W'(0) - nb) : nb;
    end

    // Publish the stepped pointers on the final acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_out <= '0;
            di_out <= '0;
        end else if (final_ack) begin
            si_out <= steps_si(op_q) ? (si_q + step) : si_q;
            di_out <= steps_di(op_q) ? (di_q + step) : di_q;
        end
    end

endmodule

// File: rtl/str_step_dp.sv
// Data path: captures read bytes per lane, supplies write bytes, and
// produces the loaded accumulator and compare operands at the end of a pass.
// Assumes LANES is a power of two so a lane index addresses the buffers.
module str_step_dp
    import str_step_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  logic [BYTE_W*LANES-1:0]  acc_in,
    input  phase_e                   phase,
    input  logic [LANE_W-1:0]        lane,
    input  logic                     mem_ack,
    input  logic [BYTE_W-1:0]        mem_rdata,
    input  logic                     final_ack,
    input  logic [2:0]               op_q,
    input  logic                     word_q,
    output logic [BYTE_W-1:0]        mem_wdata,
    output logic                     done,
    output logic [BYTE_W*LANES-1:0]  acc_out,
    output logic                     acc_load,
    output logic [BYTE_W*LANES-1:0]  cmp_a,
    output logic [BYTE_W*LANES-1:0]  cmp_b,
    output logic                     cmp_valid
);

    localparam int DATA_W = BYTE_W * LANES;

    logic [LANES-1:0][BYTE_W-1:0] src_buf, dst_buf, acc_q, src_nxt, dst_nxt;
    logic [DATA_W-1:0]            load_val, scan_val;

    // Merge the byte arriving this cycle into the capture buffers.
    always_comb begin
        src_nxt = src_buf;
        dst_nxt = dst_buf;
        if (mem_ack && (phase == PH_SRC_RD)) src_nxt[lane] = mem_rdata;
        if (mem_ack && (phase == PH_DST_RD)) dst_nxt[lane] = mem_rdata;
    end

    // Capture buffers, cleared at acceptance so unused lanes read as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_buf <= '0;
            dst_buf <= '0;
            acc_q   <= '0;
        end else if (accept) begin
            src_buf <= '0;
            dst_buf <= '0;
            acc_q   <= acc_in;
        end else begin
            src_buf <= src_nxt;
            dst_buf <= dst_nxt;
        end
    end

    // Per-lane result assembly: lane 0 always takes part, upper lanes only for words.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign load_val[g*BYTE_W +: BYTE_W] = src_nxt[g];
            assign scan_val[g*BYTE_W +: BYTE_W] = acc_q[g];
        end else begin : g_high
            assign load_val[g*BYTE_W +: BYTE_W] = word_q ? src_nxt[g] : acc_q[g];
            assign scan_val[g*BYTE_W +: BYTE_W] = word_q ? acc_q[g] : '0;
        end
    end

    // Write data: the accumulator for a store, the copied source byte for a move.
    always_comb mem_wdata = (op_q == SOP_STORE) ? acc_q[lane] : src_buf[lane];

    // End-of-pass pulses and held results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            acc_load  <= 1'b0;
            cmp_valid <= 1'b0;
            acc_out   <= '0;
            cmp_a     <= '0;
            cmp_b     <= '0;
        end else begin
            done      <= final_ack;
            acc_load  <= final_ack && (op_q == SOP_LOAD);
            cmp_valid <= final_ack && ((op_q == SOP_COMPARE) || (op_q == SOP_SCAN));
            if (final_ack) begin
                case (op_q)
                    SOP_LOAD:    acc_out <= load_val;
                    SOP_COMPARE: begin
                        cmp_a <= src_nxt;
                        cmp_b <= dst_nxt;
                    end
                    SOP_SCAN:    begin
                        cmp_a <= scan_val;
                        cmp_b <= dst_nxt;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/str_step.sv
// Top of the string stepper: one pass of a string operation over a byte-wide
// request/acknowledge memory port.
// Assumes the memory holds mem_ack low while mem_req is low.
module str_step
    import str_step_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int ADDR_W    = 20,
    parameter int BYTE_W    = 8,
    parameter int LANES     = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2:0]              op,
    input  logic                    is_word,
    input  logic                    dir_down,
    input  logic [OFS_W-1:0]        si_in,
    input  logic [OFS_W-1:0]        di_in,
    input  logic [OFS_W-1:0]        ds_in,
    input  logic [OFS_W-1:0]        es_in,
    input  logic [BYTE_W*LANES-1:0] acc_in,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [BYTE_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [BYTE_W-1:0]       mem_rdata,
    output logic                    done,
    output logic [OFS_W-1:0]        si_out,
    output logic [OFS_W-1:0]        di_out,
    output logic [BYTE_W*LANES-1:0] acc_out,
    output logic                    acc_load,
    output logic [BYTE_W*LANES-1:0] cmp_a,
    output logic [BYTE_W*LANES-1:0] cmp_b,
    output logic                    cmp_valid
);

    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    phase_e            phase;
    logic [LANE_W-1:0] lane;
    logic [2:0]        op_q;
    logic              word_q;
    logic              accept;
    logic              final_ack;

    // Memory port control follows the sequencer phase.
    always_comb begin
        mem_req = (phase != PH_IDLE);
        mem_we  = (phase == PH_DST_WR);
    end

    str_step_seq #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .is_word   (is_word),
        .mem_ack   (mem_ack),
        .phase     (phase),
        .lane      (lane),
        .op_q      (op_q),
        .word_q    (word_q),
        .accept    (accept),
        .final_ack (final_ack)
    );

    str_step_agu #(
        .OFS_W     (OFS_W),
        .SEG_SHIFT (SEG_SHIFT),
        .ADDR_W    (ADDR_W),
        .LANES     (LANES),
        .LANE_W    (LANE_W)
    ) u_agu (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .dir_down  (dir_down),
        .si_in     (si_in),
        .di_in     (di_in),
        .ds_in     (ds_in),
        .es_in     (es_in),
        .phase     (phase),
        .lane      (lane),
        .op_q      (op_q),
        .word_q    (word_q),
        .final_ack (final_ack),
        .mem_addr  (mem_addr),
        .si_out    (si_out),
        .di_out    (di_out)
    );

    str_step_dp #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .acc_in    (acc_in),
        .phase     (phase),
        .lane      (lane),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .final_ack (final_ack),
        .op_q      (op_q),
        .word_q    (word_q),
        .mem_wdata (mem_wdata),
        .done      (done),
        .acc_out   (acc_out),
        .acc_load  (acc_load),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .cmp_valid (cmp_valid)
    );

endmodule

// File: rtl/str_step_chk.sv
// Port-level protocol checker for the string stepper, bound to every instance.
// Assumes the default 16-bit pointers and 20-bit addresses.
module str_step_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [19:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        done,
    input logic        acc_load,
    input logic        cmp_valid,
    input logic [15:0] si_out,
    input logic [15:0] di_out
);

    // R8: an unacknowledged request holds its address, direction and data.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && (!mem_we || $stable(mem_wdata))));

    // R8: a write is only presented as part of a request.
    p_we_in_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R9: done lasts one cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done follows an acknowledged request and leaves the port idle.
    p_done_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_ack) && $past(mem_req) && !mem_req));

    // R9: result strobes only accompany done and never coincide.
    p_strobe_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid || acc_load) |-> (done && !(cmp_valid && acc_load)));

    // R1: the published pointers change only in a done cycle.
    p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(si_out) && $stable(di_out)));

endmodule

bind str_step str_step_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .acc_load  (acc_load),
    .cmp_valid (cmp_valid),
    .si_out    (si_out),
    .di_out    (di_out)
);

// File: tb/sim_str_step.sv
// Bench: a behavioural reference (queue of expected byte accesses plus held
// result values) compared against the ports on every falling clock edge.
module sim_str_step;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic        is_word = 1'b0;
    logic        dir_down = 1'b0;
    logic [15:0] si_in = '0, di_in = '0, ds_in = '0, es_in = '0, acc_in = '0;
    logic        mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done, acc_load, cmp_valid;
    logic [15:0] si_out, di_out, acc_out, cmp_a, cmp_b;

    always #10 clk = ~clk;

    str_step u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .is_word(is_word),
        .dir_down(dir_down), .si_in(si_in), .di_in(di_in), .ds_in(ds_in),
        .es_in(es_in), .acc_in(acc_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .si_out(si_out), .di_out(di_out),
        .acc_out(acc_out), .acc_load(acc_load), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cmp_valid(cmp_valid)
    );

    typedef struct packed {
        logic [19:0] a;
        logic        we;
        logic [7:0]  d;
    } xfer_t;

    xfer_t       q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          active = 0;
    bit          ack_drv = 0;
    int          wait_cnt = 0;
    bit          exp_done, exp_cmpv, exp_accl;
    logic [15:0] m_si = '0, m_di = '0, m_acc = '0, m_ca = '0, m_cb = '0;
    logic [15:0] p_si, p_di, p_acc, p_ca, p_cb;
    int          p_op = 0;
    string       seq_tag = "R11";
    string       res_tag = "R11";

    // Memory contents as a fixed function of the address.
    function automatic logic [7:0] fmem(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[3:0]} ^ 8'h5A;
    endfunction

    // Byte address from segment, offset and byte index, per R2.
    function automatic logic [19:0] addr_of(input logic [15:0] seg, input logic [15:0] ofs, input int b);
        logic [15:0] o;
        int unsigned lin;
        o   = ofs + 16'(b);
        lin = (int'(seg) * 16 + int'(o)) % 32'h100000;
        return 20'(lin);
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One falling-edge step of the reference: retire, compare, drive.
    task automatic tick();
        exp_done = 0;
        exp_cmpv = 0;
        exp_accl = 0;
        if (ack_drv) begin
            if (q.size() > 0) void'(q.pop_front());
            if (q.size() == 0 && active) begin
                active   = 0;
                exp_done = 1;
                m_si     = p_si;
                m_di     = p_di;
                if (p_op == 3) begin m_acc = p_acc; exp_accl = 1; end
                if (p_op == 1 || p_op == 2) begin m_ca = p_ca; m_cb = p_cb; exp_cmpv = 1; end
            end
        end
        chk("R9", "done", 32'(done), 32'(exp_done));
        chk("R9", "cmp_valid", 32'(cmp_valid), 32'(exp_cmpv));
        chk("R9", "acc_load", 32'(acc_load), 32'(exp_accl));
        chk("R1", "si_out", 32'(si_out), 32'(m_si));
        chk("R1", "di_out", 32'(di_out), 32'(m_di));
        chk(res_tag, "acc_out", 32'(acc_out), 32'(m_acc));
        chk(res_tag, "cmp_a", 32'(cmp_a), 32'(m_ca));
        chk(res_tag, "cmp_b", 32'(cmp_b), 32'(m_cb));
        chk("R8", "mem_req", 32'(mem_req), 32'(q.size() > 0));
        if (q.size() > 0 && mem_req) begin
            chk("R2", "mem_addr", 32'(mem_addr), 32'(q[0].a));
            chk(seq_tag, "mem_we", 32'(mem_we), 32'(q[0].we));
            if (q[0].we) chk(seq_tag, "mem_wdata", 32'(mem_wdata), 32'(q[0].d));
        end
        start     = 1'b0;
        ack_drv   = 0;
        mem_rdata = 8'h00;
        if (q.size() > 0) begin
            if (wait_cnt == 0) begin
                ack_drv   = 1;
                wait_cnt  = int'($urandom_range(0, 2));
                mem_rdata = q[0].we ? 8'h00 : fmem(q[0].a);
            end else begin
                wait_cnt--;
            end
        end
        mem_ack = ack_drv;
    endtask

    task automatic step();
        @(negedge clk);
        tick();
    endtask

    // Drive a start request and, if the reference accepts it, queue its accesses.
    task automatic launch(input logic [2:0] o, input bit w, input bit dr,
                          input logic [15:0] si, input logic [15:0] di,
                          input logic [15:0] ds, input logic [15:0] es,
                          input logic [15:0] acc);
        int          n;
        logic [15:0] sv, dv, st;
        logic [7:0]  b8;
        op = o; is_word = w; dir_down = dr;
        si_in = si; di_in = di; ds_in = ds; es_in = es; acc_in = acc;
        start = 1'b1;
        if (active) return;
        if (o > 3'd4) begin
            seq_tag = "R10";
            return;
        end
        n  = w ? 2 : 1;
        sv = '0;
        dv = '0;
        if (o == 3'd0 || o == 3'd1 || o == 3'd3)
            for (int b = 0; b < n; b++) begin
                b8 = fmem(addr_of(ds, si, b));
                sv[b*8 +: 8] = b8;
                q.push_back('{a: addr_of(ds, si, b), we: 1'b0, d: 8'h00});
            end
        if (o == 3'd1 || o == 3'd2)
            for (int b = 0; b < n; b++) begin
                dv[b*8 +: 8] = fmem(addr_of(es, di, b));
                q.push_back('{a: addr_of(es, di, b), we: 1'b0, d: 8'h00});
            end
        if (o == 3'd0 || o == 3'd4)
            for (int b = 0; b < n; b++)
                q.push_back('{a: addr_of(es, di, b), we: 1'b1,
                              d: (o == 3'd0) ? sv[b*8 +: 8] : acc[b*8 +: 8]});
        st   = dr ? (16'h0000 - 16'(n)) : 16'(n);
        p_si = (o == 3'd0 || o == 3'd1 || o == 3'd3) ? si + st : si;
        p_di = (o == 3'd3) ? di : di + st;
        p_op = int'(o);
        p_acc = w ? sv : {acc[15:8], sv[7:0]};
        p_ca  = (o == 3'd1) ? sv : (w ? acc : {8'h00, acc[7:0]});
        p_cb  = dv;
        case (o)
            3'd0: seq_tag = "R3";
            3'd1: seq_tag = "R4";
            3'd2: seq_tag = "R5";
            3'd3: seq_tag = "R6";
            default: seq_tag = "R7";
        endcase
        res_tag  = seq_tag;
        active   = 1;
        wait_cnt = int'($urandom_range(0, 2));
    endtask

    task automatic finish_pass();
        int guard = 0;
        while (active && guard < 100) begin
            step();
            guard++;
        end
        step();
    endtask

    task automatic run(input logic [2:0] o, input bit w, input bit dr,
                       input logic [15:0] si, input logic [15:0] di,
                       input logic [15:0] ds, input logic [15:0] es,
                       input logic [15:0] acc);
        launch(o, w, dr, si, di, ds, es, acc);
        finish_pass();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R11: reset state at the ports.
        chk("R11", "mem_req", 32'(mem_req), 32'd0);
        chk("R11", "done", 32'(done), 32'd0);
        chk("R11", "si_out", 32'(si_out), 32'd0);
        chk("R11", "di_out", 32'(di_out), 32'd0);
        chk("R11", "acc_out", 32'(acc_out), 32'd0);
        chk("R11", "cmp_a", 32'(cmp_a), 32'd0);
        step();

        // Directed passes across operations, sizes and directions.
        run(3'd0, 1'b0, 1'b0, 16'h0100, 16'h0200, 16'h1000, 16'h2000, 16'h0000); // R3 byte up
        run(3'd0, 1'b1, 1'b1, 16'h0300, 16'h0400, 16'h1234, 16'h4321, 16'h0000); // R3 word down
        run(3'd1, 1'b0, 1'b0, 16'h0010, 16'h0020, 16'h0001, 16'h0002, 16'h0000); // R4 byte
        run(3'd1, 1'b1, 1'b1, 16'h8000, 16'h7FFF, 16'hA000, 16'hB000, 16'h0000); // R4 word
        run(3'd2, 1'b0, 1'b0, 16'h5555, 16'h0040, 16'h0000, 16'h0800, 16'hBEEF); // R5 byte
        run(3'd2, 1'b1, 1'b1, 16'h5555, 16'h0041, 16'h0000, 16'h0800, 16'hBEEF); // R5 word
        run(3'd3, 1'b0, 1'b0, 16'h0900, 16'h1111, 16'h0030, 16'h0000, 16'hA5C3); // R6 byte keeps high
        run(3'd3, 1'b1, 1'b0, 16'h0902, 16'h1111, 16'h0030, 16'h0000, 16'hA5C3); // R6 word
        run(3'd4, 1'b1, 1'b0, 16'h2222, 16'h0600, 16'h0000, 16'h0050, 16'h1357); // R7 word
        run(3'd4, 1'b0, 1'b1, 16'h2222, 16'h0000, 16'h0000, 16'h0050, 16'h00EE); // R7 byte, R1 wrap down
        run(3'd3, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 16'h0100, 16'h0000, 16'h0000); // R2 offset wrap, R1 wrap up
        run(3'd4, 1'b1, 1'b0, 16'h0000, 16'h0020, 16'h0000, 16'hFFFF, 16'h4242); // R2 20-bit truncation
        run(3'd0, 1'b1, 1'b1, 16'h0001, 16'h0000, 16'hFFFF, 16'hFFF0, 16'h0000); // R1 word wrap down

        // R10: illegal codes issue nothing.
        for (int c = 5; c < 8; c++) begin
            launch(3'(c), 1'b1, 1'b0, 16'h1000, 16'h2000, 16'h3000, 16'h4000, 16'hFFFF);
            repeat (4) step();
        end

        // R10: a start while a pass is pending is ignored.
        launch(3'd0, 1'b1, 1'b0, 16'h0A00, 16'h0B00, 16'h0C00, 16'h0D00, 16'h0000);
        step();
        step();
        launch(3'd2, 1'b0, 1'b1, 16'hDEAD, 16'hBEEF, 16'h0101, 16'h0202, 16'h7777);
        finish_pass();

        // Mixed passes with edge-biased pointers.
        for (int i = 0; i < 300; i++) begin
            logic [2:0]  ro;
            logic [15:0] rsi, rdi;
            ro  = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
            rsi = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
            rdi = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom);
            launch(ro, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rsi, rdi,
                   16'($urandom), 16'($urandom), 16'($urandom));
            if (($urandom_range(0, 4) == 0) && active) begin
                step();
                launch(3'($urandom_range(0, 4)), 1'b1, 1'b0, 16'h1111, 16'h2222,
                       16'h3333, 16'h4444, 16'h5555);
            end
            finish_pass();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule